// File: doc/BRIEF.md
# 8-bit ALU with condition flags

This block is the arithmetic and logic unit of a small two-accumulator processor. Each cycle it can accept one operation on two 8-bit operands (`opnd_a` is the first or only operand, `opnd_b` the second). It computes the result from those operands and from the carry bit it keeps in its own five-bit condition register. One clock edge later it presents the result, a write strobe for the destination, and the updated half-carry, negative, zero, overflow and carry flags.

All arithmetic is two's complement. Compare and bit test update the flags but suppress the write, so the destination keeps its value. The carry bit feeds add-with-carry and both rotates. The half-carry bit follows the low nibble of additions only. Instruction decoding, memory access and the interrupt mask are handled outside this block.

Top module: `acc_alu`

## Requirements
- R1: While `rst_n` is low, and after its release until the first operation, `result` is 0, `wr_en` is 0 and `flags` is 0. The flags bit layout is h=bit 4, n=bit 3, z=bit 2, v=bit 1, c=bit 0.
- R2: Add (code 0) produces a+b. Add with carry (code 1) produces a+b+c. For both, c is the carry out of bit 7, v is signed overflow, and h is the carry from bit 3 into bit 4.
- R3: Subtract (code 2) produces a-b. Negate (code 4) produces 0-a. For both, c is set on a borrow (unsigned subtrahend greater than minuend) and v is signed overflow. So negate sets c for any nonzero a and sets v only for a=0x80.
- R4: Compare (code 3) and bit test (code 12) set the flags exactly as subtract and AND would. `wr_en` stays 0 and `result` keeps its previous value.
- R5: Increment (code 5) and decrement (code 6) produce a+1 and a-1. v is set only when a=0x7F for increment and a=0x80 for decrement. c is left unchanged.
- R6: One's complement (code 8, ~a), AND (code 9), OR (code 10) and XOR (code 11) clear v and leave c unchanged.
- R7: Clear (code 7) produces 0 with n=0, z=1, v=0, c=0.
- R8: Rotate left (code 13) gives {a[6:0],c} with new c=a[7]. Rotate right (code 14) gives {c,a[7:1]} with new c=a[0]. For both, v is new n XOR new c.
- R9: For every accepted operation, n equals bit 7 of the computed value and z is set when all 8 of its bits are 0.
- R10: h changes only on add and add with carry. Every other operation leaves it unchanged.
- R11: With `op_valid` low, or with the unused code 15, the flags and `result` hold and `wr_en` is 0.
- R12: Outputs change only at the clock edge that samples `op_valid` high, so they appear one cycle after the operation is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 4 | Operation code (see requirements) |
| opnd_a | input | 8 | First or only operand |
| opnd_b | input | 8 | Second operand |
| result | output | 8 | Registered result of the last writing operation |
| wr_en | output | 1 | Result of the previous cycle's operation is to be written |
| flags | output | 5 | Condition register {h,n,z,v,c} |

## Verification
A corrupted condition register shows on `flags` one edge after the operation that wrote it. A wrong carry also corrupts `result` on the next add with carry or rotate. A wrong half-carry hold stays visible on `flags` through every later non-add operation. A broken write suppression shows as `wr_en` high, or `result` changing, one cycle after a compare or bit test. The reference model recomputes every flag from integer arithmetic on each cycle, so any of these shows up on the first cycle it occurs.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int ALU_DW   = 8;
  localparam int ALU_HALF = ALU_DW / 2;
  localparam int ALU_MSB  = ALU_DW - 1;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0, OP_ADC = 4'd1, OP_SUB = 4'd2, OP_CMP = 4'd3,
    OP_NEG = 4'd4, OP_INC = 4'd5, OP_DEC = 4'd6, OP_CLR = 4'd7,
    OP_COM = 4'd8, OP_AND = 4'd9, OP_OR  = 4'd10, OP_XOR = 4'd11,
    OP_BIT = 4'd12, OP_ROL = 4'd13, OP_ROR = 4'd14, OP_NOP = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic h;
    logic n;
    logic z;
    logic v;
    logic c;
  } alu_flags_t;

  typedef struct packed {
    logic [ALU_DW-1:0] res;
    logic              h;
    logic              v;
    logic              c;
  } arith_out_t;

  // x + y + ci with carry out, half carry and signed overflow
  function automatic arith_out_t add_fn(input logic [ALU_DW-1:0] x,
                                        input logic [ALU_DW-1:0] y,
                                        input logic ci);
    arith_out_t o;
    logic [ALU_DW:0]   s;
    logic [ALU_HALF:0] lo;
    s  = {1'b0, x} + {1'b0, y} + {{ALU_DW{1'b0}}, ci};
    lo = {1'b0, x[ALU_HALF-1:0]} + {1'b0, y[ALU_HALF-1:0]} + {{ALU_HALF{1'b0}}, ci};
    o.res = s[ALU_DW-1:0];
    o.c   = s[ALU_DW];
    o.h   = lo[ALU_HALF];
    o.v   = (x[ALU_MSB] == y[ALU_MSB]) && (s[ALU_MSB] != x[ALU_MSB]);
    return o;
  endfunction

  // x - y with borrow in the carry position
  function automatic arith_out_t sub_fn(input logic [ALU_DW-1:0] x,
                                        input logic [ALU_DW-1:0] y);
    arith_out_t o;
    logic [ALU_DW:0] d;
    d = {1'b0, x} - {1'b0, y};
    o.res = d[ALU_DW-1:0];
    o.c   = d[ALU_DW];
    o.h   = 1'b0;
    o.v   = (x[ALU_MSB] != y[ALU_MSB]) && (d[ALU_MSB] != x[ALU_MSB]);
    return o;
  endfunction
endpackage

// File: rtl/alu_arith.sv
module alu_arith
  import alu_pkg::*;
(
  input  alu_op_e           op,
  input  logic [ALU_DW-1:0] a,
  input  logic [ALU_DW-1:0] b,
  input  logic              cin,
  output arith_out_t        ao,
  output logic              hit,
  output logic              c_upd,
  output logic              h_upd
);
  localparam logic [ALU_DW-1:0] ONE  = {{(ALU_DW-1){1'b0}}, 1'b1};
  localparam logic [ALU_DW-1:0] ZERO = '0;

  always_comb begin
    ao    = '0;
    hit   = 1'b1;
    c_upd = 1'b1;
    h_upd = 1'b0;
    unique case (op)
      OP_ADD: begin ao = add_fn(a, b, 1'b0); h_upd = 1'b1; end
      OP_ADC: begin ao = add_fn(a, b, cin);  h_upd = 1'b1; end
      OP_SUB,
      OP_CMP: ao = sub_fn(a, b);
      OP_NEG: ao = sub_fn(ZERO, a);
      OP_INC: begin ao = add_fn(a, ONE, 1'b0); c_upd = 1'b0; end
      OP_DEC: begin ao = sub_fn(a, ONE);       c_upd = 1'b0; end
      default: begin hit = 1'b0; c_upd = 1'b0; end
    endcase
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_pkg::*;
(
  input  alu_op_e           op,
  input  logic [ALU_DW-1:0] a,
  input  logic [ALU_DW-1:0] b,
  input  logic              cin,
  output logic [ALU_DW-1:0] res,
  output logic              v,
  output logic              c,
  output logic              c_upd,
  output logic              hit
);
  always_comb begin
    res   = '0;
    v     = 1'b0;
    c     = 1'b0;
    c_upd = 1'b0;
    hit   = 1'b1;
    unique case (op)
      OP_CLR: c_upd = 1'b1;
      OP_COM: res = ~a;
      OP_AND,
      OP_BIT: res = a & b;
      OP_OR:  res = a | b;
      OP_XOR: res = a ^ b;
      OP_ROL: begin
        res   = {a[ALU_MSB-1:0], cin};
        c     = a[ALU_MSB];
        c_upd = 1'b1;
        v     = a[ALU_MSB-1] ^ a[ALU_MSB];
      end
      OP_ROR: begin
        res   = {cin, a[ALU_MSB:1]};
        c     = a[0];
        c_upd = 1'b1;
        v     = cin ^ a[0];
      end
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_state.sv
module alu_state
  import alu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic              wr_nxt,
  input  logic [ALU_DW-1:0] res_nxt,
  input  alu_flags_t        flg_nxt,
  output logic [ALU_DW-1:0] res_q,
  output logic              wr_q,
  output alu_flags_t        flg_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      wr_q  <= 1'b0;
      flg_q <= '0;
    end else begin
      wr_q <= upd & wr_nxt;
      if (upd) begin
        flg_q <= flg_nxt;
        if (wr_nxt) res_q <= res_nxt;
      end
    end
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import alu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [3:0]        op_code,
  input  logic [ALU_DW-1:0] opnd_a,
  input  logic [ALU_DW-1:0] opnd_b,
  output logic [ALU_DW-1:0] result,
  output logic              wr_en,
  output logic [4:0]        flags
);
  alu_op_e           op;
  alu_flags_t        cur, nxt;
  arith_out_t        ar;
  logic              ar_hit, ar_cupd, ar_hupd;
  logic [ALU_DW-1:0] lg_res, val;
  logic              lg_v, lg_c, lg_cupd, lg_hit;
  // named events for the checker
  logic              known_op, test_op, flag_upd, c_upd, h_upd;

  assign op = alu_op_e'(op_code);

  alu_arith u_arith (
    .op(op), .a(opnd_a), .b(opnd_b), .cin(cur.c),
    .ao(ar), .hit(ar_hit), .c_upd(ar_cupd), .h_upd(ar_hupd)
  );

  alu_logic u_logic (
    .op(op), .a(opnd_a), .b(opnd_b), .cin(cur.c),
    .res(lg_res), .v(lg_v), .c(lg_c), .c_upd(lg_cupd), .hit(lg_hit)
  );

  assign known_op = ar_hit | lg_hit;
  assign test_op  = (op == OP_CMP) || (op == OP_BIT);
  assign flag_upd = op_valid & known_op;
  assign c_upd    = ar_hit ? ar_cupd : lg_cupd;
  assign h_upd    = ar_hupd;
  assign val      = ar_hit ? ar.res : lg_res;

  always_comb begin
    nxt.n = val[ALU_MSB];
    nxt.z = (val == '0);
    nxt.v = ar_hit ? ar.v : lg_v;
    nxt.c = c_upd ? (ar_hit ? ar.c : lg_c) : cur.c;
    nxt.h = h_upd ? ar.h : cur.h;
  end

  alu_state u_state (
    .clk(clk), .rst_n(rst_n), .upd(flag_upd), .wr_nxt(~test_op),
    .res_nxt(val), .flg_nxt(nxt),
    .res_q(result), .wr_q(wr_en), .flg_q(cur)
  );

  assign flags = cur;
endmodule

// File: rtl/alu_checker.sv
module alu_checker
  import alu_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic [3:0]        op_code,
  input logic [ALU_DW-1:0] result,
  input logic              wr_en,
  input logic [4:0]        flags,
  input logic              flag_upd,
  input logic              test_op
);
  p_test_nowrite_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && test_op) |=> (!wr_en && $stable(result)));

  p_n_track_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (flags[3] == result[ALU_MSB]));

  p_z_track_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (flags[2] == (result == '0)));

  p_h_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code != OP_ADD && op_code != OP_ADC) |=> $stable(flags[4]));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_upd |=> (!wr_en && $stable(flags) && $stable(result)));

  p_incdec_c_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == OP_INC || op_code == OP_DEC)) |=> $stable(flags[0]));

  p_clr_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_CLR) |=> (result == '0 && flags[3:0] == 4'b0100));

  p_logic_v_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == OP_COM || op_code == OP_AND || op_code == OP_OR ||
                  op_code == OP_XOR)) |=> (!flags[1] && $stable(flags[0])));
endmodule

bind acc_alu alu_checker i_alu_checker (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
  .result(result), .wr_en(wr_en), .flags(flags),
  .flag_upd(flag_upd), .test_op(test_op)
);

// File: tb/test_acc_alu.sv
`timescale 1ns/1ps
module test_acc_alu;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [3:0] op_code = 4'd0;
  logic [7:0] opnd_a = 8'd0, opnd_b = 8'd0;
  logic [7:0] result;
  logic       wr_en;
  logic [4:0] flags;

  int total = 0;
  int bad = 0;
  // reference state
  int m_res = 0, m_wr = 0;
  int mh = 0, mn = 0, mz = 0, mv = 0, mc = 0;

  acc_alu i_acc_alu (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result), .wr_en(wr_en), .flags(flags)
  );

  always #5 clk = ~clk;

  function automatic int sgn(int x);
    return (x >= 128) ? x - 256 : x;
  endfunction

  function automatic string tag_of(int op);
    case (op)
      0, 1:   return "R2";
      2, 4:   return "R3";
      3, 12:  return "R4";
      5, 6:   return "R5";
      7:      return "R7";
      8, 9, 10, 11: return "R6";
      13, 14: return "R8";
      default: return "R11";
    endcase
  endfunction

  // behavioural reference: update model state for one accepted operation
  task automatic model(int op, int a, int b, int valid);
    int r, s, w;
    if (!valid || op == 15) begin
      m_wr = 0;
      return;
    end
    w = 1;
    r = 0;
    case (op)
      0, 1: begin
        s  = a + b + ((op == 1) ? mc : 0);
        r  = s % 256;
        mh = (((a % 16) + (b % 16) + ((op == 1) ? mc : 0)) > 15) ? 1 : 0;
        s  = sgn(a) + sgn(b) + ((op == 1) ? mc : 0);
        mv = (s > 127 || s < -128) ? 1 : 0;
        mc = ((a + b + ((op == 1) ? mc : 0)) > 255) ? 1 : 0;
      end
      2, 3: begin
        r  = (a - b + 256) % 256;
        s  = sgn(a) - sgn(b);
        mv = (s > 127 || s < -128) ? 1 : 0;
        mc = (b > a) ? 1 : 0;
        if (op == 3) w = 0;
      end
      4: begin
        r  = (256 - a) % 256;
        mv = (-sgn(a) > 127) ? 1 : 0;
        mc = (a != 0) ? 1 : 0;
      end
      5: begin r = (a + 1) % 256; mv = (sgn(a) + 1 > 127) ? 1 : 0; end
      6: begin r = (a + 255) % 256; mv = (sgn(a) - 1 < -128) ? 1 : 0; end
      7: begin r = 0; mv = 0; mc = 0; end
      8: begin r = 255 - a; mv = 0; end
      9, 12: begin r = a & b; mv = 0; if (op == 12) w = 0; end
      10: begin r = a | b; mv = 0; end
      11: begin r = a ^ b; mv = 0; end
      13: begin r = ((a * 2) % 256) + mc; mc = a / 128; end
      default: begin r = mc * 128 + a / 2; mc = a % 2; end
    endcase
    mn = (r >= 128) ? 1 : 0;
    mz = (r == 0) ? 1 : 0;
    if (op == 13 || op == 14) mv = mn ^ mc;
    m_wr = w;
    if (w) m_res = r;
  endtask

  task automatic compare(string tag);
    logic [4:0] ef;
    ef = {mh[0], mn[0], mz[0], mv[0], mc[0]};
    total++;
    if (result !== m_res[7:0] || wr_en !== m_wr[0] || flags !== ef) begin
      bad++;
      $display("FAIL %s (R9 R10): result=%h/%h wr_en=%b/%b flags=%b/%b",
               tag, result, m_res[7:0], wr_en, m_wr[0], flags, ef);
    end
  endtask

  // called at a falling edge; checks one edge later (R12 latency)
  task automatic run_op(int op, int a, int b, int valid = 1);
    op_code  = op[3:0];
    opnd_a   = a[7:0];
    opnd_b   = b[7:0];
    op_valid = valid[0];
    model(op, a, b, valid);
    @(posedge clk);
    @(negedge clk);
    compare(valid ? tag_of(op) : "R11");
  endtask

  // R12: presenting an operation does not change outputs before the edge
  task automatic run_lat(int op, int a, int b);
    logic [7:0] r0;
    logic [4:0] f0;
    r0 = result;
    f0 = flags;
    op_code  = op[3:0];
    opnd_a   = a[7:0];
    opnd_b   = b[7:0];
    op_valid = 1'b1;
    #2;
    total++;
    if (result !== r0 || flags !== f0 || wr_en !== m_wr[0]) begin
      bad++;
      $display("FAIL R12: result=%h/%h flags=%b/%b", result, r0, flags, f0);
    end
    model(op, a, b, 1);
    @(posedge clk);
    @(negedge clk);
    compare("R12");
  endtask

  initial begin
    #(10 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog: run did not end");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int bl[8];
    bl = '{0, 1, 15, 16, 127, 128, 255, 0};
    repeat (3) @(negedge clk);
    // R1: reset state
    total++;
    if (result !== 8'd0 || wr_en !== 1'b0 || flags !== 5'd0) begin
      bad++;
      $display("FAIL R1: result=%h/00 wr_en=%b/0 flags=%b/00000", result, wr_en, flags);
    end
    rst_n = 1'b1;
    @(negedge clk);
    total++;
    if (result !== 8'd0 || wr_en !== 1'b0 || flags !== 5'd0) begin
      bad++;
      $display("FAIL R1: after release result=%h/00 wr_en=%b/0 flags=%b/00000",
               result, wr_en, flags);
    end
    // directed corner cases
    run_lat(0, 8'h7F, 8'h01);  // R2 overflow and half carry
    run_op(0, 8'hFF, 8'h01);   // R2 carry, zero
    run_op(1, 8'h10, 8'h20);   // R2 add with carry in
    run_op(2, 8'h00, 8'h01);   // R3 borrow
    run_op(2, 8'h80, 8'h01);   // R3 signed overflow
    run_op(3, 8'h05, 8'h05);   // R4 compare, no write
    run_op(12, 8'hF0, 8'h0F);  // R4 bit test, no write
    run_op(4, 8'h80, 0);       // R3 negate 0x80
    run_op(4, 8'h00, 0);       // R3 negate zero
    run_op(5, 8'h7F, 0);       // R5 increment boundary
    run_op(6, 8'h80, 0);       // R5 decrement boundary
    run_op(6, 8'h00, 0);       // R5 wrap, C held
    run_op(7, 8'h55, 8'hAA);   // R7 clear
    run_op(13, 8'h80, 0);      // R8 rotate left into carry
    run_op(13, 8'h01, 0);      // R8 carry back in
    run_op(14, 8'h01, 0);      // R8 rotate right
    run_op(14, 8'h00, 0);      // R8 carry into bit 7
    run_op(8, 8'h0F, 0);       // R6 complement
    run_op(0, 8'h12, 8'h34, 0);   // R11 idle
    run_op(15, 8'hFF, 8'hFF);     // R11 unused code
    run_lat(9, 8'hC3, 8'h3C);     // R12 and R6
    // sweep every operation over all first operands and boundary seconds
    for (int op = 0; op < 15; op++) begin
      for (int a = 0; a < 256; a++) begin
        for (int k = 0; k < 8; k++) begin
          run_op(op, a, (k == 7) ? (a * 37 + 11) % 256 : bl[k]);
        end
      end
      run_op(op, 8'hAA, 8'h55, 0);  // R11 idle between sweeps
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule